// File: doc/BRIEF.md
# Status Flag and Condition Unit

This block holds the sign, zero and carry flags of a small 18-bit accumulator processor and decides whether a branch or skip is taken. Each cycle the sequencer presents an operation class, the destination register group, a shift or rotate direction, and the ALU side results: result sign, result-zero, ALU carry out, the bits that leave a shift at either end, and the top register bit used by an upward rotate. When the step strobe is high, the flags update on that clock edge according to the class.

Only operations that target the general registers change the flags. Operations that target the index registers leave them alone, although an index register can still be tested for zero through a separate condition input. Shifts always write the flags. With-carry operations chain the zero flag, so a 36-bit value held in two words tests as zero only when both halves are zero. A flag-rotate class moves the three flags upward or downward as a ring. The condition output is combinational from the flags, a 2-bit selector and an invert bit. The unit also supplies the carry-in for the ALU.

Top module: `flag_cond_unit`

## Requirements
- R1: While rst_ni is low, sign_o, zero_o and carry_o are all 0.
- R2: In a cycle with step_i low, no flag changes at the next clock edge, whatever the other inputs are.
- R3: For step_i high, op_cls_i of 1 (plain ALU) or 3 (compare) and dst_gp_i high, the flags after the edge are sign_o = res_neg_i, zero_o = res_zero_i, carry_o = alu_cout_i.
- R4: For op_cls_i of 1, 2, 3 or 4 with dst_gp_i low (index destination), all flags keep their values.
- R5: For op_cls_i of 2 (with-carry ALU) or 4 (with-carry compare) and dst_gp_i high, sign and carry load as in R3, and zero_o becomes res_zero_i AND the previous zero_o.
- R6: For op_cls_i of 5 (shift) the flags load regardless of dst_gp_i: sign_o = res_neg_i, zero_o = res_zero_i, and carry_o = shl_out_i when dir_i is 0 (left) or shr_out_i when dir_i is 1 (right).
- R7: For op_cls_i of 6 (rotate) with dir_i 0 (upward): the new zero is the old carry, the new sign is the old zero, the new carry is rot_in_i.
- R8: For op_cls_i of 6 with dir_i 1 (downward): the new sign is the old carry, the new zero is the old sign, the new carry is the old zero.
- R9: With idx_test_i low, cond_o is the flag chosen by cond_sel_i (0 zero, 1 sign, 2 not-carry, 3 constant true), XOR cond_inv_i, combinationally.
- R10: With idx_test_i high, cond_o is ix_zero_i XOR cond_inv_i, independent of the flags.
- R11: cy_in_o equals carry_o when op_cls_i is 2 or 4, whatever dst_gp_i is, and is 0 for every other class.
- R12: op_cls_i of 0 (other) leaves all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Flag-write enable for this cycle |
| op_cls_i | input | 3 | Operation class (0 other, 1 ALU, 2 ALU with carry, 3 compare, 4 compare with carry, 5 shift, 6 rotate) |
| dst_gp_i | input | 1 | Destination is a general register |
| dir_i | input | 1 | 0 left/upward, 1 right/downward |
| res_neg_i | input | 1 | Result sign bit |
| res_zero_i | input | 1 | Result is zero |
| alu_cout_i | input | 1 | ALU carry out |
| shl_out_i | input | 1 | Bit leaving the sign position on a left shift |
| shr_out_i | input | 1 | Bit leaving bit 0 on a right shift |
| rot_in_i | input | 1 | Top register bit fed to carry on an upward rotate |
| cond_sel_i | input | 2 | Condition select |
| cond_inv_i | input | 1 | Invert the condition |
| idx_test_i | input | 1 | Test ix_zero_i instead of a flag |
| ix_zero_i | input | 1 | Selected index register is zero |
| sign_o | output | 1 | Sign flag |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry flag |
| cond_o | output | 1 | Condition true |
| cy_in_o | output | 1 | Carry into the ALU |

## Verification
The properties assume the class code stays within the seven defined values and that the ALU-side inputs are stable around the clock edge, since a reserved code of 7 is treated like class 0 and is not a case the checks cover. The stimulus keeps to that range: every vector and directed step drives a defined class on the falling edge and holds it through the rising edge. It also assumes dir_i is meaningful only for shift and rotate, so vectors for other classes leave it at 0.

// File: rtl/flag_cond_pkg.sv
package flag_cond_pkg;
  typedef enum logic [2:0] {
    CLS_OTHER  = 3'd0,
    CLS_ALU    = 3'd1,
    CLS_ALU_CY = 3'd2,
    CLS_CMP    = 3'd3,
    CLS_CMP_CY = 3'd4,
    CLS_SHIFT  = 3'd5,
    CLS_ROT    = 3'd6
  } op_cls_e;

  typedef enum logic [1:0] {
    FW_HOLD = 2'd0,
    FW_LOAD = 2'd1,
    FW_UP   = 2'd2,
    FW_DOWN = 2'd3
  } fw_mode_e;

  typedef enum logic [1:0] {
    CY_ALU = 2'd0,
    CY_SHL = 2'd1,
    CY_SHR = 2'd2
  } cy_src_e;

  typedef enum logic [1:0] {
    CS_ZERO   = 2'd0,
    CS_SIGN   = 2'd1,
    CS_NCARRY = 2'd2,
    CS_ALWAYS = 2'd3
  } cond_sel_e;

  typedef struct packed {
    logic s;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/flag_mode_dec.sv
module flag_mode_dec
  import flag_cond_pkg::*;
(
  input  logic     step_i,
  input  op_cls_e  cls_i,
  input  logic     dst_gp_i,
  input  logic     dir_i,
  output fw_mode_e mode_o,
  output cy_src_e  cy_src_o,
  output logic     chain_o,
  output logic     with_cy_o
);
  always_comb begin
    mode_o    = FW_HOLD;
    cy_src_o  = CY_ALU;
    with_cy_o = (cls_i == CLS_ALU_CY) || (cls_i == CLS_CMP_CY);
    chain_o   = with_cy_o;
    unique case (cls_i)
      CLS_ALU, CLS_ALU_CY, CLS_CMP, CLS_CMP_CY:
        if (step_i && dst_gp_i) mode_o = FW_LOAD;
      CLS_SHIFT: begin
        if (step_i) mode_o = FW_LOAD;
        cy_src_o = dir_i ? CY_SHR : CY_SHL;
      end
      CLS_ROT:
        if (step_i) mode_o = dir_i ? FW_DOWN : FW_UP;
      default: mode_o = FW_HOLD;
    endcase
  end
endmodule

// File: rtl/flag_store.sv
module flag_store
  import flag_cond_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  fw_mode_e mode_i,
  input  cy_src_e  cy_src_i,
  input  logic     chain_i,
  input  logic     res_neg_i,
  input  logic     res_zero_i,
  input  logic     alu_cout_i,
  input  logic     shl_out_i,
  input  logic     shr_out_i,
  input  logic     rot_in_i,
  output flags_t   flags_o
);
  flags_t q, d;
  logic   cy_new;

  always_comb begin
    unique case (cy_src_i)
      CY_SHL:  cy_new = shl_out_i;
      CY_SHR:  cy_new = shr_out_i;
      default: cy_new = alu_cout_i;
    endcase
  end

  always_comb begin
    d = q;
    unique case (mode_i)
      FW_LOAD: begin
        d.s = res_neg_i;
        d.z = chain_i ? (res_zero_i & q.z) : res_zero_i;
        d.c = cy_new;
      end
      FW_UP: begin
        d.z = q.c;
        d.s = q.z;
        d.c = rot_in_i;
      end
      FW_DOWN: begin
        d.s = q.c;
        d.z = q.s;
        d.c = q.z;
      end
      default: d = q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign flags_o = q;
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import flag_cond_pkg::*;
(
  input  flags_t    flags_i,
  input  cond_sel_e sel_i,
  input  logic      inv_i,
  input  logic      idx_test_i,
  input  logic      ix_zero_i,
  output logic      cond_o
);
  logic flag_bit;

  always_comb begin
    unique case (sel_i)
      CS_ZERO:   flag_bit = flags_i.z;
      CS_SIGN:   flag_bit = flags_i.s;
      CS_NCARRY: flag_bit = ~flags_i.c;
      default:   flag_bit = 1'b1;
    endcase
  end

  assign cond_o = (idx_test_i ? ix_zero_i : flag_bit) ^ inv_i;
endmodule

// File: rtl/flag_cond_unit.sv
module flag_cond_unit
  import flag_cond_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic [2:0] op_cls_i,
  input  logic       dst_gp_i,
  input  logic       dir_i,
  input  logic       res_neg_i,
  input  logic       res_zero_i,
  input  logic       alu_cout_i,
  input  logic       shl_out_i,
  input  logic       shr_out_i,
  input  logic       rot_in_i,
  input  logic [1:0] cond_sel_i,
  input  logic       cond_inv_i,
  input  logic       idx_test_i,
  input  logic       ix_zero_i,
  output logic       sign_o,
  output logic       zero_o,
  output logic       carry_o,
  output logic       cond_o,
  output logic       cy_in_o
);
  fw_mode_e mode;
  cy_src_e  cy_src;
  logic     chain, with_cy;
  flags_t   flags;

  flag_mode_dec u_dec (
    .step_i    (step_i),
    .cls_i     (op_cls_e'(op_cls_i)),
    .dst_gp_i  (dst_gp_i),
    .dir_i     (dir_i),
    .mode_o    (mode),
    .cy_src_o  (cy_src),
    .chain_o   (chain),
    .with_cy_o (with_cy)
  );

  flag_store u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .cy_src_i   (cy_src),
    .chain_i    (chain),
    .res_neg_i  (res_neg_i),
    .res_zero_i (res_zero_i),
    .alu_cout_i (alu_cout_i),
    .shl_out_i  (shl_out_i),
    .shr_out_i  (shr_out_i),
    .rot_in_i   (rot_in_i),
    .flags_o    (flags)
  );

  cond_eval u_cond (
    .flags_i    (flags),
    .sel_i      (cond_sel_e'(cond_sel_i)),
    .inv_i      (cond_inv_i),
    .idx_test_i (idx_test_i),
    .ix_zero_i  (ix_zero_i),
    .cond_o     (cond_o)
  );

  assign sign_o  = flags.s;
  assign zero_o  = flags.z;
  assign carry_o = flags.c;
  assign cy_in_o = with_cy & flags.c;
endmodule

// File: rtl/flag_cond_chk.sv
module flag_cond_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       step_i,
  input logic [2:0] op_cls_i,
  input logic       dst_gp_i,
  input logic       dir_i,
  input logic       shl_out_i,
  input logic       shr_out_i,
  input logic       rot_in_i,
  input logic [1:0] cond_sel_i,
  input logic       cond_inv_i,
  input logic       idx_test_i,
  input logic       ix_zero_i,
  input logic       sign_o,
  input logic       zero_o,
  input logic       carry_o,
  input logic       cond_o,
  input logic       cy_in_o
);
  logic alu_grp;
  assign alu_grp = (op_cls_i >= 3'd1) && (op_cls_i <= 3'd4);

  always @(posedge clk_i)
    if (!rst_ni) p_reset_clear_r1: assert ({sign_o, zero_o, carry_o} == 3'b000);

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable({sign_o, zero_o, carry_o}));

  p_index_dst_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && alu_grp && !dst_gp_i |=> $stable({sign_o, zero_o, carry_o}));

  p_zero_chain_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && dst_gp_i && (op_cls_i == 3'd2 || op_cls_i == 3'd4) && !zero_o |=> !zero_o);

  p_shift_carry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && op_cls_i == 3'd5 |=> carry_o == ($past(dir_i) ? $past(shr_out_i) : $past(shl_out_i)));

  p_rot_up_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && op_cls_i == 3'd6 && !dir_i |=>
      zero_o == $past(carry_o) && sign_o == $past(zero_o) && carry_o == $past(rot_in_i));

  p_rot_down_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && op_cls_i == 3'd6 && dir_i |=>
      sign_o == $past(carry_o) && zero_o == $past(sign_o) && carry_o == $past(zero_o));

  p_always_true_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idx_test_i && cond_sel_i == 2'd3 |-> cond_o == !cond_inv_i);

  p_index_test_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_test_i |-> cond_o == (ix_zero_i ^ cond_inv_i));

  p_no_cy_in_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(op_cls_i == 3'd2 || op_cls_i == 3'd4) |-> !cy_in_o);

  p_other_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_cls_i == 3'd0 |=> $stable({sign_o, zero_o, carry_o}));
endmodule

bind flag_cond_unit flag_cond_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .op_cls_i(op_cls_i),
  .dst_gp_i(dst_gp_i), .dir_i(dir_i), .shl_out_i(shl_out_i), .shr_out_i(shr_out_i),
  .rot_in_i(rot_in_i), .cond_sel_i(cond_sel_i), .cond_inv_i(cond_inv_i),
  .idx_test_i(idx_test_i), .ix_zero_i(ix_zero_i), .sign_o(sign_o), .zero_o(zero_o),
  .carry_o(carry_o), .cond_o(cond_o), .cy_in_o(cy_in_o)
);

// File: tb/flag_cond_unit_bench.sv
module flag_cond_unit_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       step_i = 1'b0;
  logic [2:0] op_cls_i = '0;
  logic       dst_gp_i = 1'b0, dir_i = 1'b0;
  logic       res_neg_i = 1'b0, res_zero_i = 1'b0, alu_cout_i = 1'b0;
  logic       shl_out_i = 1'b0, shr_out_i = 1'b0, rot_in_i = 1'b0;
  logic [1:0] cond_sel_i = '0;
  logic       cond_inv_i = 1'b0, idx_test_i = 1'b0, ix_zero_i = 1'b0;
  logic       sign_o, zero_o, carry_o, cond_o, cy_in_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  flag_cond_unit u_flag_cond_unit (
    .clk_i(clk), .rst_ni(rst_ni), .step_i(step_i), .op_cls_i(op_cls_i),
    .dst_gp_i(dst_gp_i), .dir_i(dir_i), .res_neg_i(res_neg_i), .res_zero_i(res_zero_i),
    .alu_cout_i(alu_cout_i), .shl_out_i(shl_out_i), .shr_out_i(shr_out_i),
    .rot_in_i(rot_in_i), .cond_sel_i(cond_sel_i), .cond_inv_i(cond_inv_i),
    .idx_test_i(idx_test_i), .ix_zero_i(ix_zero_i), .sign_o(sign_o), .zero_o(zero_o),
    .carry_o(carry_o), .cond_o(cond_o), .cy_in_o(cy_in_o)
  );

  // cls[13:11] dst[10] dir[9] neg zr cout shl shr rot [8:3] expected {s,z,c}[2:0]
  localparam int NV = 14;
  localparam logic [13:0] VEC [NV] = '{
    14'b001_1_0_101000_101,
    14'b001_0_0_010000_101,
    14'b011_1_0_010000_010,
    14'b010_1_0_011000_011,
    14'b010_1_0_000000_000,
    14'b100_1_0_010000_000,
    14'b101_0_0_100100_101,
    14'b101_0_1_010100_010,
    14'b110_0_0_000001_101,
    14'b110_0_1_000000_110,
    14'b000_1_0_001000_110,
    14'b110_0_1_000000_011,
    14'b001_1_0_000000_000,
    14'b010_0_0_111000_000
  };

  function automatic string vtag(int i);
    case (i)
      0, 2, 12: return "R3";
      1, 13:    return "R4";
      3, 4, 5:  return "R5";
      6, 7:     return "R6";
      8:        return "R7";
      9, 11:    return "R8";
      default:  return "R12";
    endcase
  endfunction

  task automatic check(string req, logic [2:0] got, logic [2:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic drive(logic st, logic [13:0] v);
    @(negedge clk);
    step_i = st;
    {op_cls_i, dst_gp_i, dir_i, res_neg_i, res_zero_i, alu_cout_i,
     shl_out_i, shr_out_i, rot_in_i} = v[13:3];
  endtask

  task automatic after_edge();
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1", {sign_o, zero_o, carry_o}, 3'b000);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i]);
      after_edge();
      check(vtag(i), {sign_o, zero_o, carry_o}, VEC[i][2:0]);
    end

    // R2: idle step with a loading class
    drive(1'b0, 14'b001_1_0_111000_000);
    after_edge();
    check("R2", {sign_o, zero_o, carry_o}, 3'b000);

    // R9 with flags 000
    step_i = 1'b0;
    for (int s = 0; s < 4; s++) begin
      for (int n = 0; n < 2; n++) begin
        @(negedge clk);
        cond_sel_i = s[1:0];
        cond_inv_i = n[0];
        #1;
        check("R9", {2'b00, cond_o}, {2'b00, ((s >= 2) ? 1'b1 : 1'b0) ^ n[0]});
      end
    end

    // load 111 then R9 again
    drive(1'b1, 14'b001_1_0_111000_000);
    after_edge();
    check("R3", {sign_o, zero_o, carry_o}, 3'b111);
    step_i = 1'b0;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      cond_sel_i = s[1:0];
      cond_inv_i = 1'b0;
      #1;
      check("R9", {2'b00, cond_o}, {2'b00, (s == 2) ? 1'b0 : 1'b1});
    end

    // R10: index test ignores flags
    @(negedge clk);
    cond_sel_i = 2'd0; idx_test_i = 1'b1; ix_zero_i = 1'b0; cond_inv_i = 1'b0;
    #1; check("R10", {2'b00, cond_o}, 3'b000);
    ix_zero_i = 1'b1;
    #1; check("R10", {2'b00, cond_o}, 3'b001);
    cond_inv_i = 1'b1;
    #1; check("R10", {2'b00, cond_o}, 3'b000);
    idx_test_i = 1'b0; cond_inv_i = 1'b0;

    // R11: carry-in with flags 111, step low
    @(negedge clk);
    step_i = 1'b0; dst_gp_i = 1'b0; op_cls_i = 3'd2;
    #1; check("R11", {2'b00, cy_in_o}, 3'b001);
    op_cls_i = 3'd4; dst_gp_i = 1'b1;
    #1; check("R11", {2'b00, cy_in_o}, 3'b001);
    op_cls_i = 3'd1;
    #1; check("R11", {2'b00, cy_in_o}, 3'b000);
    op_cls_i = 3'd5;
    #1; check("R11", {2'b00, cy_in_o}, 3'b000);

    // R1: reset mid-run clears flags
    @(negedge clk);
    rst_ni = 1'b0;
    #2;
    check("R1", {sign_o, zero_o, carry_o}, 3'b000);
    @(negedge clk);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule